// File: doc/BRIEF.md
# Smart-card T=0 character receiver

This block receives single characters from a smart card over a shared, open-drain I/O line. Its clock is the card clock. One bit period (the elementary time unit, ETU) lasts a programmable number of card-clock cycles. The receiver waits for a falling edge and confirms the start bit at its mid-point. It then samples eight data bits, least significant first, and a parity bit, each at the middle of its bit period. The parity bit is checked against the selected even or odd rule.

A character that passes the check goes into a holding register, and a ready flag is raised. If the previous character was not yet read, an overrun flag is also raised. A character with wrong parity is discarded. The receiver signals the fault back to the card by pulling the line low for exactly one bit period inside the guard time, which asks the card to send the character again.

A saturating counter records the parity failures and returns to zero when it is read. An inhibit control makes the receiver accept faulty characters as good. In that mode it sends no low pulse and counts nothing.

Top module: `sc_t0_rx`

## Requirements
- R1: After reset, the ready flag, the overrun flag, the error count and the line pull-down output are all zero.
- R2: A low level in idle starts a character only if the line is still low `etu_cycles_i/2` cycles later. Otherwise the receiver returns to idle, stores nothing, counts no error and does not pull the line low.
- R3: After a confirmed start, each of the nine following bits is sampled one ETU after the previous sample. The first eight bits form the data byte, least significant bit first. An accepted byte appears on `hold_data_o` with `hold_ready_o` set.
- R4: With `odd_parity_i` = 0, parity is good when the eight data bits together with the parity bit hold an even number of ones. With `odd_parity_i` = 1, that number must be odd.
- R5: A character with bad parity, received while inhibit is off, leaves `hold_data_o` and `hold_ready_o` unchanged.
- R6: For such a character, `io_pull_low_o` goes high exactly one ETU after the parity sample, which is half an ETU into the first guard bit. It stays high for exactly `etu_cycles_i` cycles and is then released.
- R7: Each bad-parity character received with inhibit off adds one to `err_count_o`. The count holds at 255 once it reaches that value.
- R8: A one-cycle pulse on `err_read_i` makes `err_count_o` read zero on the following cycle, unless a new error is recorded in that same cycle.
- R9: With `nack_inhibit_i` = 1, a bad-parity character is stored and flagged ready like a good one. No pull-down is driven and the error count does not change.
- R10: A pulse on `hold_read_i` clears `hold_ready_o` on the next cycle, unless a new character is accepted in that same cycle.
- R11: A character accepted while `hold_ready_o` is set, with no read in that cycle, replaces the data and sets `overrun_o`. A read clears `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_line_i | input | 1 | Present level of the shared I/O line |
| io_pull_low_o | output | 1 | High while the receiver pulls the line low (open drain) |
| etu_cycles_i | input | ETU_W | Card-clock cycles per bit period, at least 4 |
| odd_parity_i | input | 1 | 0 selects even parity, 1 selects odd parity |
| nack_inhibit_i | input | 1 | Accept bad-parity characters without signalling |
| hold_read_i | input | 1 | Read strobe for the holding register |
| hold_data_o | output | 8 | Last accepted data byte |
| hold_ready_o | output | 1 | Unread byte present |
| overrun_o | output | 1 | A byte was replaced before it was read |
| err_read_i | input | 1 | Read strobe for the error counter |
| err_count_o | output | ERR_W | Saturating count of parity failures |

## Verification
The assertions assume that `etu_cycles_i`, `odd_parity_i` and `nack_inhibit_i` do not change while a character is in progress. They also assume that `io_line_i` changes only away from the rising clock edge. The stimulus changes these controls only while the line has been idle for several bit periods. It drives every line level on the falling clock edge and models the shared line as the AND of the card's level and the inverted pull-down output. Bit periods of 4, 5 and 8 cycles cover both odd and even half-period rounding.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_GUARD,
    ST_NACK
  } rx_state_e;

  // True when data plus parity bit match the selected rule (odd=0: even count of ones)
  function automatic logic parity_good(input logic [7:0] data, input logic pbit, input logic odd);
    return (^{data, pbit}) == odd;
  endfunction

  // Counter value at which the start bit mid-point is reached
  function automatic logic [15:0] mid_offset(input logic [15:0] etu);
    return (etu >> 1) - 16'd1;
  endfunction

  // Saturating error count step; a read clears, a coincident error leaves one
  function automatic logic [15:0] err_next(input logic [15:0] cur, input logic [15:0] top,
                                           input logic inc, input logic clr);
    if (clr) return inc ? 16'd1 : 16'd0;
    if (inc && cur != top) return cur + 16'd1;
    return cur;
  endfunction

endpackage

// File: rtl/sc_rx_frame.sv
module sc_rx_frame
  import sc_rx_pkg::*;
#(
  parameter int ETU_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [ETU_W-1:0] etu_i,
  input  logic             odd_i,
  input  logic             inhibit_i,
  output logic             char_evt_o,
  output logic [7:0]       char_data_o,
  output logic             char_ok_o,
  output logic             pull_low_o
);
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(8);

  rx_state_e        state_q;
  logic [ETU_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       shift_q;
  logic             nack_pend_q;
  logic             pull_q;

  logic [ETU_W-1:0] half_m1;
  logic [ETU_W-1:0] full_m1;
  logic             mid_hit;
  logic             full_hit;

  assign half_m1  = ETU_W'(mid_offset(16'(etu_i)));
  assign full_m1  = etu_i - 1'b1;
  assign mid_hit  = (cnt_q == half_m1);
  assign full_hit = (cnt_q == full_m1);

  // Named event: parity bit sampled this cycle
  assign char_evt_o  = (state_q == ST_BITS) && full_hit && (idx_q == LAST_IDX);
  assign char_data_o = shift_q;
  assign char_ok_o   = parity_good(shift_q, line_i, odd_i);
  assign pull_low_o  = pull_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shift_q     <= '0;
      nack_pend_q <= 1'b0;
      pull_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (!line_i) state_q <= ST_START;
        end
        ST_START: begin
          if (mid_hit) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= line_i ? ST_IDLE : ST_BITS;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_BITS: begin
          if (full_hit) begin
            cnt_q <= '0;
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) begin
              nack_pend_q <= !char_ok_o && !inhibit_i;
              state_q     <= ST_GUARD;
            end else begin
              shift_q <= {line_i, shift_q[7:1]};
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GUARD: begin
          if (full_hit) begin
            cnt_q <= '0;
            if (nack_pend_q) begin
              state_q <= ST_NACK;
              pull_q  <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_NACK: begin
          if (full_hit) begin
            cnt_q       <= '0;
            pull_q      <= 1'b0;
            nack_pend_q <= 1'b0;
            state_q     <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Run length of the pull-down, kept for the length check only
  logic [ETU_W-1:0] pull_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pull_run_q <= '0;
    else if (pull_q) pull_run_q <= pull_run_q + 1'b1;
    else             pull_run_q <= '0;
  end

  assert_nack_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pull_q |-> (pull_run_q < etu_i));

  assert_nack_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !inhibit_i);

endmodule

// File: rtl/sc_rx_hold.sv
module sc_rx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_i,
  input  logic       ok_i,
  input  logic       inhibit_i,
  input  logic [7:0] data_i,
  input  logic       rd_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       overrun_o
);
  logic       accept;
  logic [7:0] data_q;
  logic       ready_q;
  logic       ovr_q;

  assign accept    = evt_i && (ok_i || inhibit_i);
  assign data_o    = data_q;
  assign ready_o   = ready_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (accept) begin
      data_q  <= data_i;
      ready_q <= 1'b1;
      ovr_q   <= (ovr_q && !rd_i) || (ready_q && !rd_i);
    end else if (rd_i) begin
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end
  end

  assert_bad_not_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !ok_i && !inhibit_i) |=> ($stable(data_q) && ($stable(ready_q) || !ready_q)));

  assert_ready_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !evt_i) |=> !ready_q);

  assert_overrun_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && (ok_i || inhibit_i) && ready_q && !rd_i) |=> ovr_q);

endmodule

// File: rtl/sc_rx_errcnt.sv
module sc_rx_errcnt
  import sc_rx_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] count_o
);
  localparam logic [ERR_W-1:0] TOP = {ERR_W{1'b1}};

  logic [ERR_W-1:0] cnt_q;
  logic [ERR_W-1:0] cnt_nxt;

  assign cnt_nxt = ERR_W'(err_next(16'(cnt_q), 16'(TOP), inc_i, clr_i));
  assign count_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assert_err_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr_i) |=> (cnt_q == TOP));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_q == '0));

endmodule

// File: rtl/sc_t0_rx.sv
module sc_t0_rx #(
  parameter int ETU_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_line_i,
  output logic             io_pull_low_o,
  input  logic [ETU_W-1:0] etu_cycles_i,
  input  logic             odd_parity_i,
  input  logic             nack_inhibit_i,
  input  logic             hold_read_i,
  output logic [7:0]       hold_data_o,
  output logic             hold_ready_o,
  output logic             overrun_o,
  input  logic             err_read_i,
  output logic [ERR_W-1:0] err_count_o
);
  logic       char_evt;
  logic [7:0] char_data;
  logic       char_ok;
  logic       err_evt;

  assign err_evt = char_evt && !char_ok && !nack_inhibit_i;

  sc_rx_frame #(.ETU_W(ETU_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (io_line_i),
    .etu_i      (etu_cycles_i),
    .odd_i      (odd_parity_i),
    .inhibit_i  (nack_inhibit_i),
    .char_evt_o (char_evt),
    .char_data_o(char_data),
    .char_ok_o  (char_ok),
    .pull_low_o (io_pull_low_o)
  );

  sc_rx_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (char_evt),
    .ok_i     (char_ok),
    .inhibit_i(nack_inhibit_i),
    .data_i   (char_data),
    .rd_i     (hold_read_i),
    .data_o   (hold_data_o),
    .ready_o  (hold_ready_o),
    .overrun_o(overrun_o)
  );

  sc_rx_errcnt #(.ERR_W(ERR_W)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (err_evt),
    .clr_i  (err_read_i),
    .count_o(err_count_o)
  );

endmodule

// File: tb/sc_t0_rx_tb.sv
module sc_t0_rx_tb;
  localparam int ETU_W = 16;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             drv_line = 1'b1;
  logic             io_line;
  logic             io_pull_low;
  logic [ETU_W-1:0] etu = 16'd8;
  logic             odd_par = 1'b0;
  logic             inhib = 1'b0;
  logic             mon_rd = 1'b0;
  logic             task_rd = 1'b0;
  logic             err_rd = 1'b0;
  logic [7:0]       hold_data;
  logic             hold_ready;
  logic             overrun;
  logic [ERR_W-1:0] err_count;

  assign io_line = drv_line & ~io_pull_low;

  sc_t0_rx #(.ETU_W(ETU_W), .ERR_W(ERR_W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_line_i     (io_line),
    .io_pull_low_o (io_pull_low),
    .etu_cycles_i  (etu),
    .odd_parity_i  (odd_par),
    .nack_inhibit_i(inhib),
    .hold_read_i   (mon_rd | task_rd),
    .hold_data_o   (hold_data),
    .hold_ready_o  (hold_ready),
    .overrun_o     (overrun),
    .err_read_i    (err_rd),
    .err_count_o   (err_count)
  );

  int         checks = 0;
  int         errors = 0;
  int         err_exp = 0;
  int         last_good = 0;
  bit         auto_read = 1'b1;
  bit         done = 1'b0;
  logic       ready_prev = 1'b0;
  logic [7:0] exp_q[$];

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: pops the expected byte on every rise of the ready flag
  always @(negedge clk) begin
    if (mon_rd) check_eq("R10", "ready after read", int'(hold_ready), 0);
    mon_rd = 1'b0;
    if (rst_n && hold_ready && !ready_prev) begin
      if (exp_q.size() == 0) check_eq("R3", "unexpected byte", 1, 0);
      else check_eq("R3", "received byte", int'(hold_data), int'(exp_q.pop_front()));
      if (auto_read) mon_rd = 1'b1;
    end
    ready_prev = hold_ready;
  end

  // Driver: sends one character and measures any pull-down in the guard time
  task automatic send_char(input logic [7:0] d, input bit bad, input bit push);
    int ones = 0;
    int e = int'(etu);
    logic pbit;
    bit nack;
    bit accept;
    int pulls = 0;
    int first = -1;
    logic [9:0] frame;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    pbit   = odd_par ? logic'((ones % 2) == 0) : logic'((ones % 2) == 1);
    pbit   = pbit ^ bad;
    nack   = bad && !inhib;
    accept = !bad || inhib;
    if (accept && push) exp_q.push_back(d);
    if (accept) last_good = int'(d);
    frame = {pbit, d, 1'b0};
    @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      drv_line = frame[j];
      repeat (e) @(negedge clk);
    end
    drv_line = 1'b1;
    for (int m = 0; m < 3 * e; m++) begin
      if (io_pull_low) begin
        pulls++;
        if (first < 0) first = m;
      end
      @(negedge clk);
    end
    if (nack) begin
      err_exp = (err_exp < 255) ? err_exp + 1 : 255;
      check_eq("R6", "pull-down length", pulls, e);
      check_eq("R6", "pull-down start", first, e / 2 + 1);
    end else begin
      check_eq(bad ? "R9" : "R4", "no pull-down", pulls, 0);
    end
    check_eq(bad && inhib ? "R9" : "R7", "error count", int'(err_count), err_exp);
    if (bad && !inhib && auto_read) begin
      check_eq("R5", "ready after bad char", int'(hold_ready), 0);
      check_eq("R5", "data after bad char", int'(hold_data), last_good);
    end
  endtask

  initial begin
    int pulls;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "ready", int'(hold_ready), 0);
    check_eq("R1", "overrun", int'(overrun), 0);
    check_eq("R1", "error count", int'(err_count), 0);
    check_eq("R1", "pull-down", int'(io_pull_low), 0);

    // Even parity, 8-cycle bit period (R3, R4)
    send_char(8'hA5, 1'b0, 1'b1);
    send_char(8'h3C, 1'b0, 1'b1);
    send_char(8'h00, 1'b0, 1'b1);
    send_char(8'hFF, 1'b0, 1'b1);
    send_char(8'h01, 1'b0, 1'b1);
    // Bad parity (R5, R6, R7)
    send_char(8'h5A, 1'b1, 1'b1);

    // Short glitch instead of a start bit (R2)
    drv_line = 1'b0;
    repeat (2) @(negedge clk);
    drv_line = 1'b1;
    pulls = 0;
    for (int k = 0; k < 120; k++) begin
      if (io_pull_low) pulls++;
      @(negedge clk);
    end
    check_eq("R2", "ready after glitch", int'(hold_ready), 0);
    check_eq("R2", "errors after glitch", int'(err_count), err_exp);
    check_eq("R2", "pull-down after glitch", pulls, 0);
    send_char(8'h81, 1'b0, 1'b1);

    // Odd parity, 5-cycle bit period (R4)
    etu = 16'd5;
    odd_par = 1'b1;
    repeat (10) @(negedge clk);
    send_char(8'h96, 1'b0, 1'b1);
    send_char(8'h01, 1'b0, 1'b1);
    send_char(8'h7E, 1'b1, 1'b1);

    // Inhibit mode (R9)
    inhib = 1'b1;
    repeat (10) @(negedge clk);
    send_char(8'h42, 1'b1, 1'b1);
    inhib = 1'b0;
    repeat (10) @(negedge clk);

    // Clear on read of the error counter (R8)
    check_eq("R8", "count before read", int'(err_count), 2);
    err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
    check_eq("R8", "count after read", int'(err_count), 0);
    err_exp = 0;

    // Overrun (R11)
    auto_read = 1'b0;
    send_char(8'h11, 1'b0, 1'b1);
    send_char(8'h22, 1'b0, 1'b0);
    check_eq("R11", "overrun flag", int'(overrun), 1);
    check_eq("R11", "replaced data", int'(hold_data), 8'h22);
    check_eq("R11", "ready held", int'(hold_ready), 1);
    task_rd = 1'b1;
    @(negedge clk);
    task_rd = 1'b0;
    check_eq("R10", "ready after manual read", int'(hold_ready), 0);
    check_eq("R11", "overrun after read", int'(overrun), 0);
    auto_read = 1'b1;

    // Saturation at 255, 4-cycle bit period (R7)
    etu = 16'd4;
    odd_par = 1'b0;
    repeat (10) @(negedge clk);
    for (int n = 0; n < 258; n++) send_char(8'(n), 1'b1, 1'b1);
    check_eq("R7", "saturated count", int'(err_count), 255);
    err_rd = 1'b1;
    @(negedge clk);
    err_rd = 1'b0;
    check_eq("R8", "count after saturated read", int'(err_count), 0);

    repeat (10) @(negedge clk);
    check_eq("R3", "scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule